// File: doc/BRIEF.md
# Reprogrammable Two-Digit Combination Lock Controller

This block is a synchronous controller for a lock opened by entering two short digits in order. A digit is presented on the code input and confirmed with a single-cycle enter pulse. Two digit registers hold the current combination. A comparator checks each entry against the register for the digit position that the state machine is waiting for. The state machine sees only whether the entry matched. A wrong first digit is deliberately not reported straight away. The fault indication appears only once the second digit has been entered, so an observer cannot tell which digit was wrong.

Once the lock is open, a further enter starts reprogramming. The next two confirmed entries become the new first and second digits, and the lock then shows open again. A separate load-default input writes the factory combination into the digit registers. The synchronous system reset returns the state machine to its idle state and leaves the stored combination as it is.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While rst_i is high, and in the first cycle after it falls, all four status outputs are low (idle state). Reset does not change the stored digits.
- R2: A cycle with load_default_i high loads first digit 2'b11 and second digit 2'b01. This takes priority over a programming write in the same cycle, and the state machine still advances on that cycle's enter.
- R3: From idle, entering the first digit and then the second digit, each with an enter pulse, drives unlocked_o high in the cycle after the second pulse.
- R4: A mismatching first digit keeps all outputs low after the first enter. The next enter raises fault_o, whatever code it carries.
- R5: A matching first digit followed by a mismatching second digit raises fault_o.
- R6: While fault_o is high, an enter pulse returns the controller to idle (all outputs low), and a fresh attempt is evaluated normally.
- R7: While unlocked_o is high, an enter raises set_first_o. The next enter stores code_i as the first digit and raises set_second_o. The following enter stores code_i as the second digit and raises unlocked_o again.
- R8: After reprogramming, only the new combination opens the lock. The old combination leads to fault_o.
- R9: In any cycle without enter_i, the state and the stored digits hold, whatever code_i carries.
- R10: The outputs are decoded from the state alone. At most one of unlocked_o, fault_o, set_first_o and set_second_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous system reset, active high; digits kept |
| code_i | input | DIGIT_W | Digit presented by the user |
| enter_i | input | 1 | Single-cycle confirm pulse |
| load_default_i | input | 1 | Load the default combination into the digit registers |
| unlocked_o | output | 1 | Lock is open |
| fault_o | output | 1 | Wrong combination was entered |
| set_first_o | output | 1 | Waiting for the new first digit |
| set_second_o | output | 1 | Waiting for the new second digit |

## Verification
The bench goes after a wrong first digit followed by a correct second digit. A design that raised the fault early, or that compared the second entry after a bad first one, would show a fault too soon or open the lock. It checks load-default arriving in the same cycle as a programming write; a design with the wrong priority would keep the user's digit instead of the default. It checks that a reset issued after reprogramming keeps the new combination; a design that reset the digit registers would reopen with the default. Long idle stretches with a changing code catch a design that moves without enter. Random sequences weighted towards matching digits reach the open and programming states often and compare every cycle against a bench model.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
   typedef enum logic [2:0] {
      LK_IDLE  = 3'd0,
      LK_GOOD1 = 3'd1,
      LK_BAD1  = 3'd2,
      LK_OPEN  = 3'd3,
      LK_SET1  = 3'd4,
      LK_SET2  = 3'd5,
      LK_FAULT = 3'd6
   } lock_state_t;

   localparam int unsigned LK_POSITIONS = 2;
endpackage

// File: rtl/combo_lock_digits.sv
module combo_lock_digits #(
   parameter int unsigned DIGIT_W  = 2,
   parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
   parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               load_default_i,
   input  logic               wr_first_i,
   input  logic               wr_second_i,
   input  logic               sel_second_i,
   input  logic [DIGIT_W-1:0] code_i,
   output logic               match_o
);
   import combo_lock_pkg::*;

   localparam int unsigned FLAT_W = DIGIT_W * LK_POSITIONS;
   localparam logic [FLAT_W-1:0] DEF_FLAT = {DEF_SECOND, DEF_FIRST};

   logic [LK_POSITIONS-1:0] wr_en;
   logic [FLAT_W-1:0]       digits;
   logic [DIGIT_W-1:0]      expected;

   assign wr_en = {wr_second_i, wr_first_i};

   for (genvar p = 0; p < LK_POSITIONS; p++) begin : g_pos
      logic [DIGIT_W-1:0] digit_q;
      always_ff @(posedge clk_i) begin
         if (load_default_i)
            digit_q <= DEF_FLAT[p*DIGIT_W +: DIGIT_W];
         else if (wr_en[p])
            digit_q <= code_i;
      end
      assign digits[p*DIGIT_W +: DIGIT_W] = digit_q;
   end

   assign expected = sel_second_i ? digits[DIGIT_W +: DIGIT_W] : digits[0 +: DIGIT_W];
   assign match_o  = (code_i == expected);

   // R2: default values appear after a load
   a_r2_default_load: assert property (@(posedge clk_i) disable iff (rst_i)
      load_default_i |=> (digits == DEF_FLAT));
   // R9: digits hold without a load or a write
   a_r9_digits_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_default_i && !wr_first_i && !wr_second_i) |=> $stable(digits));
   // R7: a write lands the code in the first position
   a_r7_first_write: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_first_i && !load_default_i) |=> (digits[0 +: DIGIT_W] == $past(code_i)));
endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic                        enter_i,
   input  logic                        match_i,
   output logic                        sel_second_o,
   output logic                        wr_first_o,
   output logic                        wr_second_o,
   output combo_lock_pkg::lock_state_t state_o
);
   import combo_lock_pkg::*;

   lock_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (enter_i) begin
         unique case (state_q)
            LK_IDLE:  state_d = match_i ? LK_GOOD1 : LK_BAD1;
            LK_GOOD1: state_d = match_i ? LK_OPEN  : LK_FAULT;
            LK_BAD1:  state_d = LK_FAULT;
            LK_OPEN:  state_d = LK_SET1;
            LK_SET1:  state_d = LK_SET2;
            LK_SET2:  state_d = LK_OPEN;
            LK_FAULT: state_d = LK_IDLE;
            default:  state_d = LK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= LK_IDLE;
      else       state_q <= state_d;
   end

   assign sel_second_o = (state_q == LK_GOOD1);
   assign wr_first_o   = !rst_i && enter_i && (state_q == LK_SET1);
   assign wr_second_o  = !rst_i && enter_i && (state_q == LK_SET2);
   assign state_o      = state_q;

   // R9: no enter, no move
   a_r9_state_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !enter_i |=> $stable(state_q));
   // R4: bad first digit always leads to fault
   a_r4_bad_to_fault: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == LK_BAD1 && enter_i) |=> (state_q == LK_FAULT));
   // R6: fault clears on enter
   a_r6_fault_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == LK_FAULT && enter_i) |=> (state_q == LK_IDLE));
   // R1: reset lands in idle
   a_r1_reset_idle: assert property (@(posedge clk_i)
      rst_i |=> (state_q == LK_IDLE));
endmodule

// File: rtl/combo_lock_status.sv
module combo_lock_status (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  combo_lock_pkg::lock_state_t state_i,
   output logic                        unlocked_o,
   output logic                        fault_o,
   output logic                        set_first_o,
   output logic                        set_second_o
);
   import combo_lock_pkg::*;

   assign unlocked_o   = (state_i == LK_OPEN);
   assign fault_o      = (state_i == LK_FAULT);
   assign set_first_o  = (state_i == LK_SET1);
   assign set_second_o = (state_i == LK_SET2);

   // R10: at most one indication
   a_r10_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0({unlocked_o, fault_o, set_first_o, set_second_o}));
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl #(
   parameter int unsigned DIGIT_W = 2,
   parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
   parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [DIGIT_W-1:0] code_i,
   input  logic               enter_i,
   input  logic               load_default_i,
   output logic               unlocked_o,
   output logic               fault_o,
   output logic               set_first_o,
   output logic               set_second_o
);
   import combo_lock_pkg::*;

   localparam int unsigned MAX_W = 16;

   if (DIGIT_W < 1 || DIGIT_W > MAX_W) begin : g_bad_width
      $error("combo_lock_ctrl: DIGIT_W out of range");
   end

   logic        match, sel_second, wr_first, wr_second;
   lock_state_t state;

   combo_lock_digits #(
      .DIGIT_W   (DIGIT_W),
      .DEF_FIRST (DEF_FIRST),
      .DEF_SECOND(DEF_SECOND)
   ) i_digits (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .load_default_i(load_default_i),
      .wr_first_i    (wr_first),
      .wr_second_i   (wr_second),
      .sel_second_i  (sel_second),
      .code_i        (code_i),
      .match_o       (match)
   );

   combo_lock_fsm i_fsm (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .enter_i     (enter_i),
      .match_i     (match),
      .sel_second_o(sel_second),
      .wr_first_o  (wr_first),
      .wr_second_o (wr_second),
      .state_o     (state)
   );

   combo_lock_status i_status (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .state_i     (state),
      .unlocked_o  (unlocked_o),
      .fault_o     (fault_o),
      .set_first_o (set_first_o),
      .set_second_o(set_second_o)
   );

   // R7: open plus enter starts programming
   a_r7_open_to_prog: assert property (@(posedge clk_i) disable iff (rst_i)
      (unlocked_o && enter_i) |=> set_first_o);
   // R3: second-digit wait, match and enter opens
   a_r3_open_on_match: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_second && match && enter_i) |=> unlocked_o);
endmodule

// File: tb/test_combo_lock_ctrl.sv
`timescale 1ns/1ps
module test_combo_lock_ctrl;
   localparam int W = 2;
   localparam int S_IDLE = 0, S_GOOD1 = 1, S_BAD1 = 2, S_OPEN = 3,
                  S_SET1 = 4, S_SET2 = 5, S_FAULT = 6;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] code = '0;
   logic         enter = 1'b0;
   logic         ld = 1'b0;
   logic         unl, flt, sf, ss;

   int total = 0;
   int bad = 0;
   int ms = S_IDLE;
   logic [W-1:0] md1 = 2'b11, md2 = 2'b01;

   always #4 clk = ~clk;

   combo_lock_ctrl #(.DIGIT_W(W)) i_combo_lock_ctrl (
      .clk_i(clk), .rst_i(rst), .code_i(code), .enter_i(enter),
      .load_default_i(ld), .unlocked_o(unl), .fault_o(flt),
      .set_first_o(sf), .set_second_o(ss)
   );

   function automatic int next_st(int s, bit en, logic [W-1:0] c,
                                  logic [W-1:0] d1, logic [W-1:0] d2);
      if (!en) return s;
      case (s)
         S_IDLE:  return (c == d1) ? S_GOOD1 : S_BAD1;
         S_GOOD1: return (c == d2) ? S_OPEN : S_FAULT;
         S_BAD1:  return S_FAULT;
         S_OPEN:  return S_SET1;
         S_SET1:  return S_SET2;
         S_SET2:  return S_OPEN;
         default: return S_IDLE;
      endcase
   endfunction

   function automatic logic [3:0] exp_out(int s);
      return {s == S_OPEN, s == S_FAULT, s == S_SET1, s == S_SET2};
   endfunction

   task automatic chk(string req);
      logic [3:0] act, ex;
      act = {unl, flt, sf, ss};
      ex  = exp_out(ms);
      total++;
      if (act !== ex) begin
         bad++;
         $display("FAIL %s: outputs(open,fault,set1,set2) actual=%b expected=%b", req, act, ex);
      end
   endtask

   // one cycle: drive at negedge, clock, check at next negedge
   task automatic step(logic [W-1:0] c, bit en, bit l, bit r, string req);
      int ns;
      code = c; enter = en; ld = l; rst = r;
      @(posedge clk);
      @(negedge clk);
      enter = 1'b0; ld = 1'b0; rst = 1'b0;
      ns = r ? S_IDLE : next_st(ms, en, c, md1, md2);
      if (l) begin md1 = 2'b11; md2 = 2'b01; end
      else if (!r && en && ms == S_SET1) md1 = c;
      else if (!r && en && ms == S_SET2) md2 = c;
      ms = ns;
      chk(req);
   endtask

   initial begin
      #(200000 * 8);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C1C));
      @(negedge clk);
      step(2'b00, 0, 1, 1, "R1 reset with default load");
      step(2'b00, 0, 0, 1, "R1 reset held");
      step(2'b10, 0, 0, 0, "R1 first cycle after reset");
      // R3 default combination opens
      step(2'b11, 1, 0, 0, "R3 first digit");
      step(2'b01, 1, 0, 0, "R3 second digit opens");
      // R7 reprogram to 00,10
      step(2'b00, 1, 0, 0, "R7 enter programming");
      step(2'b00, 1, 0, 0, "R7 store first");
      step(2'b10, 1, 0, 0, "R7 store second, open again");
      // R9 idle with changing code
      for (int i = 0; i < 6; i++) step(2'(i), 0, 0, 0, "R9 hold while open");
      // R1/R10 reset keeps programmed digits
      step(2'b11, 0, 0, 1, "R1 reset after programming");
      step(2'b00, 1, 0, 0, "R8 new first digit");
      step(2'b10, 1, 0, 0, "R8 new second digit opens");
      step(2'b00, 0, 0, 1, "R1 reset");
      step(2'b11, 1, 0, 0, "R8 old first digit");
      step(2'b01, 1, 0, 0, "R8 old combination faults");
      step(2'b00, 1, 0, 0, "R6 fault clears");
      // R4 wrong first, right second
      step(2'b01, 1, 0, 0, "R4 wrong first stays quiet");
      for (int i = 0; i < 3; i++) step(2'(3 - i), 0, 0, 0, "R9 hold in bad1");
      step(2'b10, 1, 0, 0, "R4 fault after second");
      step(2'b00, 1, 0, 0, "R6 back to idle");
      // R5 right first, wrong second
      step(2'b00, 1, 0, 0, "R5 first ok");
      step(2'b11, 1, 0, 0, "R5 wrong second faults");
      step(2'b00, 1, 0, 0, "R6 retry from idle");
      step(2'b00, 1, 0, 0, "R6 retry first");
      step(2'b10, 1, 0, 0, "R6 retry opens");
      // R2 load_default collides with a programming write
      step(2'b00, 1, 0, 0, "R2 enter programming");
      step(2'b00, 1, 1, 0, "R2 load wins over write");
      step(2'b10, 1, 0, 0, "R2 second write");
      step(2'b00, 1, 0, 0, "R7 start programming");
      step(2'b00, 0, 0, 1, "R1 reset mid programming");
      step(2'b11, 1, 0, 0, "R2 default first kept");
      step(2'b10, 1, 0, 0, "R2 second digit from write opens");
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [W-1:0] c;
         bit en, l, r;
         int pick;
         pick = $urandom_range(99);
         en = (pick < 55);
         l  = ($urandom_range(99) < 3);
         r  = ($urandom_range(99) < 2);
         if ($urandom_range(1) == 1)
            c = (ms == S_GOOD1) ? md2 : md1;
         else
            c = W'($urandom_range(3));
         step(c, en, l, r, "R10 random sequence");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule